// File: doc/BRIEF.md
# Kitchen Countdown Timer Core

This block holds the counting and control state of a minutes:seconds kitchen timer. A parent design supplies a one-cycle tick once per second and one-cycle strobes from four buttons: one that toggles between set and run, one that advances the preset minutes, one that advances the preset seconds, and one that silences the alarm. The strobes are expected to be debounced and synchronized already. Clock division, display scanning and segment decoding are done outside the block.

In set mode the user builds a preset time with the two increment buttons. The countdown registers keep copying the preset. In run mode the seconds drop by one on every tick. When they pass from 00 to 59, a registered borrow lowers the minutes on the following cycle. Once the countdown reads 00:00 in run mode, the block goes back to set mode and raises the alarm on the same edge. The alarm stays raised until the alarm-off button is pressed or reset is applied. The display word shows the countdown in run mode and the preset in set mode.

Top module: `kitchen_timer`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), preset and countdown are 00:00, the block is in set mode and the alarm is off. After release, time_o is 16'h0000, mode_o is 3'b001 and alarm_o is 0.
- R2: Each of the four BCD digits in time_o keeps its tens digit within 0..5 and its ones digit within 0..9.
- R3: In set mode, a min_inc_i or sec_inc_i pulse adds one to that preset field, and 59 wraps to 00. In run mode both buttons have no effect on the preset.
- R4: A start_i pulse toggles between set mode and run mode, unless the zero rule in R7 applies in that cycle.
- R5: In set mode the countdown loads the preset on every clock. On the first run cycle, time_o equals the preset shown just before start_i.
- R6: In run mode a tick_i pulse lowers the seconds by one. Going from 00 to 59 lowers the minutes one clock later. A tick_i pulse in set mode has no effect.
- R7: In run mode with a countdown of 00:00, the next edge selects set mode and sets alarm_o. Priority in one cycle is: zero first, then start_i, then alarm_off_i. The alarm holds until alarm_off_i or reset.
- R8: time_o packs minute tens, minute ones, second tens and second ones from bit 15 down to bit 0. It carries the countdown in run mode and the preset in set mode.
- R9: mode_o[1:0] is 2'b01 in set mode and 2'b10 in run mode. mode_o[2] equals alarm_o.
- R10: Starting with a preset of 00:00 gives one run cycle, then the block returns to set mode with the alarm raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe |
| start_i | input | 1 | Set/run toggle strobe |
| min_inc_i | input | 1 | Preset minute increment strobe |
| sec_inc_i | input | 1 | Preset second increment strobe |
| alarm_off_i | input | 1 | Alarm acknowledge strobe |
| time_o | output | 16 | Packed BCD mm:ss display word |
| mode_o | output | 3 | {alarm, run, set} indicator |
| alarm_o | output | 1 | Alarm drive |

## Verification
The hardest case to reach is the countdown arriving at 00:00 while start_i or alarm_off_i is pulsed in the same cycle, because R7's priority decides the outcome only there. Random presets are rarely small enough to count down within a short run. Directed phases therefore build small presets with the increment buttons, step the ticks down across a minute borrow, and pulse start_i on the exact zero cycle and together with alarm_off_i. A long random phase then checks every output on every clock against a cycle-level reference model.

// File: rtl/kt_pkg.sv
package kt_pkg;
  parameter int unsigned TENS_MAX = 5;
  parameter int unsigned ONES_MAX = 9;

  typedef logic [3:0] digit_t;
  typedef struct packed {
    digit_t tens;
    digit_t ones;
  } field_t;

  function automatic field_t field_inc(field_t f);
    field_t r;
    r = f;
    if (f.ones >= digit_t'(ONES_MAX)) begin
      r.ones = '0;
      r.tens = (f.tens >= digit_t'(TENS_MAX)) ? '0 : f.tens + 4'd1;
    end else begin
      r.ones = f.ones + 4'd1;
    end
    return r;
  endfunction

  function automatic field_t field_dec(field_t f);
    field_t r;
    r = f;
    if (f.ones == '0) begin
      r.ones = digit_t'(ONES_MAX);
      r.tens = (f.tens == '0) ? digit_t'(TENS_MAX) : f.tens - 4'd1;
    end else begin
      r.ones = f.ones - 4'd1;
    end
    return r;
  endfunction
endpackage

// File: rtl/kt_preset_field.sv
module kt_preset_field
  import kt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   inc_i,
  input  logic   hold_i,
  output field_t val_o
);
  field_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               val_q <= '0;
    else if (inc_i && !hold_i) val_q <= field_inc(val_q);
  end

  assign val_o = val_q;
endmodule

// File: rtl/kt_down_field.sv
module kt_down_field
  import kt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  field_t load_val_i,
  input  logic   dec_i,
  output field_t val_o,
  output logic   borrow_o
);
  field_t val_q;
  logic   borrow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q    <= '0;
      borrow_q <= 1'b0;
    end else if (load_i) begin
      val_q    <= load_val_i;
      borrow_q <= 1'b0;
    end else begin
      // borrow is a registered one-cycle pulse toward the next field
      borrow_q <= dec_i && (val_q == '0);
      if (dec_i) val_q <= field_dec(val_q);
    end
  end

  assign val_o    = val_q;
  assign borrow_o = borrow_q;
endmodule

// File: rtl/kt_ctrl.sv
module kt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic start_i,
  input  logic alarm_off_i,
  output logic run_o,
  output logic alarm_o
);
  logic run_q, alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else if (run_q && zero_i) begin
      run_q   <= 1'b0;
      alarm_q <= 1'b1;
    end else if (start_i) begin
      run_q   <= ~run_q;
    end else if (alarm_off_i) begin
      alarm_q <= 1'b0;
    end
  end

  assign run_o   = run_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/kitchen_timer.sv
module kitchen_timer
  import kt_pkg::*;
#(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              min_inc_i,
  input  logic              sec_inc_i,
  input  logic              alarm_off_i,
  output logic [TIME_W-1:0] time_o,
  output logic [2:0]        mode_o,
  output logic              alarm_o
);
  localparam int unsigned NUM_FIELDS = TIME_W / $bits(field_t);

  // index 0 = seconds, index NUM_FIELDS-1 = minutes
  field_t [NUM_FIELDS-1:0] preset;
  field_t [NUM_FIELDS-1:0] count;
  logic   [NUM_FIELDS-1:0] inc;
  logic   [NUM_FIELDS-1:0] dec;
  logic   [NUM_FIELDS-1:0] borrow;
  logic                    run;
  logic                    zero;

  assign inc = {min_inc_i, sec_inc_i};
  assign dec = {borrow[NUM_FIELDS-2:0], tick_i};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    kt_preset_field u_preset (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .hold_i (run),
      .val_o  (preset[g])
    );

    kt_down_field u_down (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (!run),
      .load_val_i (preset[g]),
      .dec_i      (dec[g]),
      .val_o      (count[g]),
      .borrow_o   (borrow[g])
    );
  end

  assign zero = (count == '0);

  kt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zero_i      (zero),
    .start_i     (start_i),
    .alarm_off_i (alarm_off_i),
    .run_o       (run),
    .alarm_o     (alarm_o)
  );

  assign time_o = run ? count : preset;
  assign mode_o = {alarm_o, run ? 2'b10 : 2'b01};
endmodule

// File: rtl/kt_checker.sv
module kt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        start_i,
  input logic        min_inc_i,
  input logic        sec_inc_i,
  input logic        alarm_off_i,
  input logic [15:0] time_o,
  input logic [2:0]  mode_o,
  input logic        alarm_o
);
  p_bcd_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_o[15:12] <= 4'd5 && time_o[11:8] <= 4'd9 &&
    time_o[7:4] <= 4'd5 && time_o[3:0] <= 4'd9);

  p_mode_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(mode_o[1:0]) && (mode_o[2] == alarm_o));

  p_alarm_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !alarm_off_i |=> alarm_o);

  p_zero_alarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] && time_o == 16'h0000 |=> alarm_o && mode_o[0]);

  p_run_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[0] && start_i && !min_inc_i && !sec_inc_i
    |=> mode_o[1] && time_o == $past(time_o));

  p_set_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[0] && !start_i && !min_inc_i && !sec_inc_i |=> $stable(time_o));
endmodule

bind kitchen_timer kt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .start_i     (start_i),
  .min_inc_i   (min_inc_i),
  .sec_inc_i   (sec_inc_i),
  .alarm_off_i (alarm_off_i),
  .time_o      (time_o),
  .mode_o      (mode_o),
  .alarm_o     (alarm_o)
);

// File: tb/kitchen_timer_tb.sv
`timescale 1ns/1ps
module kitchen_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 0, start_i = 0, min_inc_i = 0, sec_inc_i = 0, alarm_off_i = 0;
  logic [15:0] time_o;
  logic [2:0]  mode_o;
  logic        alarm_o;

  int n_run = 0, n_fail = 0;
  int m_pm, m_ps, m_cm, m_cs, m_b, m_run, m_al;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  kitchen_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .min_inc_i(min_inc_i), .sec_inc_i(sec_inc_i), .alarm_off_i(alarm_off_i),
    .time_o(time_o), .mode_o(mode_o), .alarm_o(alarm_o)
  );

  function automatic logic [15:0] pack(int m, int s);
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic logic [15:0] exp_time();
    return m_run ? pack(m_cm, m_cs) : pack(m_pm, m_ps);
  endfunction

  function automatic logic [2:0] exp_mode();
    return {m_al[0], m_run ? 2'b10 : 2'b01};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pm = 0; m_ps = 0; m_cm = 0; m_cs = 0; m_b = 0; m_run = 0; m_al = 0;
  endtask

  // reference update for one clock edge, from requirements
  task automatic model_step(bit t, bit st, bit mi, bit si, bit ao);
    int n_pm, n_ps, n_cm, n_cs, n_b, n_run, n_al;
    n_pm = m_pm; n_ps = m_ps; n_cm = m_cm; n_cs = m_cs; n_run = m_run; n_al = m_al; n_b = 0;
    if (m_run && m_cm == 0 && m_cs == 0) begin n_run = 0; n_al = 1; end
    else if (st) n_run = !m_run;
    else if (ao) n_al = 0;
    if (!m_run && mi) n_pm = (m_pm + 1) % 60;
    if (!m_run && si) n_ps = (m_ps + 1) % 60;
    if (!m_run) begin n_cm = m_pm; n_cs = m_ps; end
    else begin
      if (t) begin n_cs = (m_cs == 0) ? 59 : m_cs - 1; n_b = (m_cs == 0); end
      if (m_b != 0) n_cm = (m_cm == 0) ? 59 : m_cm - 1;
    end
    m_pm = n_pm; m_ps = n_ps; m_cm = n_cm; m_cs = n_cs; m_b = n_b; m_run = n_run; m_al = n_al;
  endtask

  // drive at negedge, clock once, compare at following negedge
  task automatic step(bit t, bit st, bit mi, bit si, bit ao);
    tick_i = t; start_i = st; min_inc_i = mi; sec_inc_i = si; alarm_off_i = ao;
    @(posedge clk_i);
    model_step(t, st, mi, si, ao);
    @(negedge clk_i);
    tick_i = 0; start_i = 0; min_inc_i = 0; sec_inc_i = 0; alarm_off_i = 0;
    check("R8 time", time_o, exp_time());
    check("R9 mode", 16'(mode_o), 16'(exp_mode()));
    check("R7 alarm", 16'(alarm_o), 16'(m_al[0]));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    #3;
    @(negedge clk_i);
    rst_ni = 1;
    check("R1 time", time_o, 16'h0000);
    check("R1 mode", 16'(mode_o), 16'h0001);
    check("R1 alarm", 16'(alarm_o), 16'h0000);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (2) @(negedge clk_i);
    do_reset();

    // R3 second wrap: 60 presses return to 00
    for (int i = 0; i < 60; i++) step(0, 0, 0, 1, 0);
    check("R3 wrap", time_o, 16'h0000);
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 1, 0, 0);
    check("R3 inc", time_o, 16'h0102);
    step(1, 0, 0, 0, 0);
    check("R6 set tick", time_o, 16'h0102);

    // R4/R5 enter run from preset
    step(0, 1, 0, 0, 0);
    check("R4 mode", 16'(mode_o), 16'h0002);
    check("R5 load", time_o, 16'h0102);
    step(0, 0, 1, 1, 0);
    check("R3 run ignore", time_o, 16'h0102);

    // R6 decrement and borrow
    step(1, 0, 0, 0, 0); check("R6 dec", time_o, 16'h0101);
    step(1, 0, 0, 0, 0); check("R6 dec", time_o, 16'h0100);
    step(1, 0, 0, 0, 0); check("R6 sec wrap", time_o, 16'h0159);
    step(0, 0, 0, 0, 0); check("R6 borrow", time_o, 16'h0059);

    // count to zero, R7 alarm
    while (exp_time() != 16'h0000) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R7 alarm set", 16'(alarm_o), 16'h0001);
    check("R7 back to set", 16'(mode_o), 16'h0005);
    check("R8 preset shown", time_o, 16'h0102);

    // R7 priority: start beats alarm_off
    step(0, 1, 0, 0, 1);
    check("R7 start over off", 16'(alarm_o), 16'h0001);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    check("R7 alarm clear", 16'(alarm_o), 16'h0000);

    // R10 zero preset, start again on zero cycle: zero wins
    do_reset();
    step(0, 1, 0, 0, 0);
    check("R10 run", 16'(mode_o), 16'h0002);
    step(0, 1, 0, 0, 0);
    check("R10 alarm", 16'(mode_o), 16'h0005);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, ($urandom % 40) == 0, ($urandom % 9) == 0,
           ($urandom % 7) == 0, ($urandom % 30) == 0);
      if (($urandom % 1500) == 0) do_reset();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule